// File: doc/BRIEF.md
# TDM Channel PRBS Inserter

This block places a pseudo-random test pattern into a programmable run of time slots on one stream of a group of serial TDM outputs. A bit strobe marks each bit time at the line rate, and a frame marker flags the first bit of each 125 us frame. The block keeps its own bit position within the frame. From that position it derives the current channel. Each channel holds 8 bits, and a frame holds 32, 64, 128 or 256 channels, set by a 2-bit rate select.

When insertion is on, the chosen stream carries successive bits of a maximal-length sequence during the window. The window starts at a start channel and covers that channel plus a programmed count of channels after it. During those bits the output enable of that stream is forced active. The normal source data and source enable supplied for those bits are overridden. Every other bit, and every other stream, passes the normal data and enable through. Two sequence lengths are available: 2^15-1 and 2^23-1. The generator steps only on windowed bits, so the pattern runs on across frames without restarting. Checking on the receive side is handled elsewhere and has its own enable.

Top module: `tdm_prbs_inserter`

## Requirements
- R1: While reset is high, and on the first clock after it, every bit of `ser_out` and `ser_oe` is 0.
- R2: For a bit outside the window, or with `tx_en` low, `ser_out[s]` and `ser_oe[s]` equal `sw_data[s]` and `sw_oe[s]` as sampled on the clock where `bit_en` is high, and they appear one clock later.
- R3: A stream whose index differs from `stream_sel` is never overridden.
- R4: The window covers channels `start_ch` through `start_ch + len_ch` inclusive on stream `stream_sel`. For every bit in the window, `ser_oe` of that stream is 1 and `ser_out` carries the sequence bit.
- R5: With `poly_sel` = 0, the sequence uses x^15+x^14+1. The emitted bit is state[14] XOR state[13], and the same bit is shifted into state bit 0 as the state moves one place toward the MSB. The state is set to all ones on any clock where `tx_en` is low or where `poly_sel` differs from its value on the previous clock.
- R6: With `poly_sel` = 1, the sequence uses x^23+x^18+1. The emitted bit is state[22] XOR state[17], with the same shift and seeding as R5.
- R7: The sequence state steps only on windowed bits. It carries on from frame to frame without reseeding.
- R8: A frame holds 32 << `rate_sel` channels, which is 256 << `rate_sel` bit times. A window that reaches past the last channel stops at the frame end and does not wrap. A start channel beyond the frame gives no insertion.
- R9: A bit strobe with `frame_sync` high is bit 0 of channel 0, and channel n occupies bit positions 8n to 8n+7. Without `frame_sync`, the position wraps to 0 after the last bit of the frame.
- R10: `ser_out` and `ser_oe` change only on the clock edge that samples `bit_en` high.
- R11: In the active length, the sequence state is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit strobe, one clock per line bit |
| frame_sync | input | 1 | With bit_en, marks the first bit of a frame |
| rate_sel | input | 2 | Channels per frame = 32 << rate_sel |
| tx_en | input | 1 | Enables pattern insertion |
| poly_sel | input | 1 | 0: 2^15-1 sequence, 1: 2^23-1 sequence |
| stream_sel | input | 2 | Stream that receives the pattern |
| start_ch | input | 8 | First channel of the window |
| len_ch | input | 8 | Channels following the start channel |
| sw_data | input | 4 | Normal switched data bit per stream |
| sw_oe | input | 4 | Normal output enable per stream |
| ser_out | output | 4 | Registered serial data per stream |
| ser_oe | output | 4 | Registered output enable per stream |

## Verification
On every cycle, the assertions check the following. Outputs hold between strobes. Unselected streams copy their inputs, and the enable is forced high in the window. A frame marker restarts the position, and the position stays inside the frame for the current rate. The sequence state never becomes zero. Only the bench scenarios can show the exact sequence values for both lengths, how the state runs on across frames, truncation at the frame end for different rates, and realignment on a mid-frame marker. Those scenarios compare each output bit against an independent model of the window and the sequence.

// File: rtl/tdm_prbs_pkg.sv
package tdm_prbs_pkg;
  localparam int RATE_W  = 2;
  localparam int BASE_CH = 32;
  localparam int CH_W    = 8;
  localparam int BIT_W   = 3;
  localparam int IDX_W   = CH_W + BIT_W;
  localparam int SEQ_W   = 23;

  typedef enum logic {
    SEQ_SHORT = 1'b0,
    SEQ_LONG  = 1'b1
  } seq_len_e;

  localparam logic [IDX_W:0] FRAME_BITS_MIN = (IDX_W+1)'(BASE_CH * 8);

  function automatic logic [IDX_W:0] frame_bits(input logic [RATE_W-1:0] rate);
    return FRAME_BITS_MIN << rate;
  endfunction
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter
  import tdm_prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic [RATE_W-1:0] rate_sel,
  output logic [IDX_W-1:0]  cur_idx
);
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W:0]   fb_last;

  always_comb begin
    fb_last = frame_bits(rate_sel) - (IDX_W+1)'(1);
    if (frame_sync)                      cur_idx = '0;
    else if ({1'b0, last_idx} >= fb_last) cur_idx = '0;
    else                                 cur_idx = last_idx + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         last_idx <= '1;
    else if (bit_en) last_idx <= cur_idx;
  end

  a_r9_sync_restarts: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frame_sync) |=> (last_idx == '0));

  a_r8_pos_in_frame: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bit_en)) |-> ({1'b0, last_idx} < frame_bits($past(rate_sel))));
endmodule

// File: rtl/tdm_window_match.sv
module tdm_window_match
  import tdm_prbs_pkg::*;
(
  input  logic            tx_en,
  input  logic [CH_W-1:0] cur_ch,
  input  logic [CH_W-1:0] start_ch,
  input  logic [CH_W-1:0] len_ch,
  output logic            in_win
);
  logic [CH_W:0] last_ch;

  always_comb begin
    last_ch = {1'b0, start_ch} + {1'b0, len_ch};
    in_win  = tx_en && (cur_ch >= start_ch) && ({1'b0, cur_ch} <= last_ch);
  end
endmodule

// File: rtl/tdm_prbs_gen.sv
module tdm_prbs_gen
  import tdm_prbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic advance,
  input  logic seq_sel,
  output logic seq_bit
);
  localparam int SHORT_W = 15;
  localparam int S_TAP_A = 14;
  localparam int S_TAP_B = 13;
  localparam int L_TAP_A = 22;
  localparam int L_TAP_B = 17;

  logic [SEQ_W-1:0] state;
  logic             sel_q;
  logic             reseed;

  always_comb begin
    if (seq_len_e'(seq_sel) == SEQ_LONG) seq_bit = state[L_TAP_A] ^ state[L_TAP_B];
    else                                 seq_bit = state[S_TAP_A] ^ state[S_TAP_B];
    reseed = !run || (seq_sel != sel_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '1;
      sel_q <= 1'b0;
    end else begin
      sel_q <= seq_sel;
      if (reseed)       state <= '1;
      else if (advance) state <= {state[SEQ_W-2:0], seq_bit};
    end
  end

  a_r11_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    (seq_len_e'(sel_q) == SEQ_LONG) ? (state != '0) : (state[SHORT_W-1:0] != '0));
endmodule

// File: rtl/tdm_prbs_inserter.sv
module tdm_prbs_inserter
  import tdm_prbs_pkg::*;
#(
  parameter int NSTR  = 4,
  parameter int STR_W = $clog2(NSTR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              frame_sync,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              tx_en,
  input  logic              poly_sel,
  input  logic [STR_W-1:0]  stream_sel,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [CH_W-1:0]   len_ch,
  input  logic [NSTR-1:0]   sw_data,
  input  logic [NSTR-1:0]   sw_oe,
  output logic [NSTR-1:0]   ser_out,
  output logic [NSTR-1:0]   ser_oe
);
  logic [IDX_W-1:0] cur_idx;
  logic             in_win;
  logic             seq_bit;

  tdm_slot_counter u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .rate_sel(rate_sel), .cur_idx(cur_idx)
  );

  tdm_window_match u_win (
    .tx_en(tx_en), .cur_ch(cur_idx[IDX_W-1:BIT_W]), .start_ch(start_ch),
    .len_ch(len_ch), .in_win(in_win)
  );

  tdm_prbs_gen u_gen (
    .clk(clk), .rst(rst), .run(tx_en), .advance(bit_en && in_win),
    .seq_sel(poly_sel), .seq_bit(seq_bit)
  );

  for (genvar i = 0; i < NSTR; i++) begin : g_str
    logic hit;
    assign hit = in_win && (stream_sel == STR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        ser_out[i] <= 1'b0;
        ser_oe[i]  <= 1'b0;
      end else if (bit_en) begin
        ser_out[i] <= hit ? seq_bit : sw_data[i];
        ser_oe[i]  <= hit | sw_oe[i];
      end
    end

    a_r3_other_stream_pass: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(bit_en) && ($past(stream_sel) != STR_W'(i)))
        |-> (ser_out[i] == $past(sw_data[i]) && ser_oe[i] == $past(sw_oe[i])));
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (ser_out == '0 && ser_oe == '0));

  a_r4_oe_forced: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bit_en && in_win)) |-> ser_oe[$past(stream_sel)]);

  a_r10_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bit_en)) |-> ($stable(ser_out) && $stable(ser_oe)));
endmodule

// File: tb/test_tdm_prbs_inserter.sv
module test_tdm_prbs_inserter;
  localparam int NSTR = 4;

  typedef struct {
    logic [NSTR-1:0] d;
    logic [NSTR-1:0] oe;
    string           tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic bit_en = 0, frame_sync = 0, tx_en = 0, poly_sel = 0;
  logic [1:0] rate_sel = 0, stream_sel = 0;
  logic [7:0] start_ch = 0, len_ch = 0;
  logic [NSTR-1:0] sw_data = 0, sw_oe = 0;
  logic [NSTR-1:0] ser_out, ser_oe;

  int n_chk = 0, n_fail = 0;
  exp_t q[$];
  logic be_seen = 0;
  logic [NSTR-1:0] held_d = 0, held_oe = 0;
  logic [22:0] m_seq = '1;
  int m_idx = 0;
  bit done = 0;
  string cur_tag = "R2";

  always #5 clk = ~clk;

  tdm_prbs_inserter i_tdm_prbs_inserter (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_sync(frame_sync),
    .rate_sel(rate_sel), .tx_en(tx_en), .poly_sel(poly_sel),
    .stream_sel(stream_sel), .start_ch(start_ch), .len_ch(len_ch),
    .sw_data(sw_data), .sw_oe(sw_oe), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always @(posedge clk) be_seen <= bit_en && !rst;

  task automatic check(input bit ok, input string tag, input logic [NSTR-1:0] ad,
                       input logic [NSTR-1:0] ao, input logic [NSTR-1:0] ed,
                       input logic [NSTR-1:0] eo);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b", tag, ad, ao, ed, eo);
    end
  endtask

  // monitor: pops the scoreboard after each strobe, checks hold otherwise (R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (be_seen) begin
        if (q.size() == 0) check(0, "scoreboard empty", ser_out, ser_oe, 0, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(ser_out == e.d && ser_oe == e.oe, e.tag, ser_out, ser_oe, e.d, e.oe);
        end
        held_d = ser_out; held_oe = ser_oe;
      end else if (held_d != ser_out || held_oe != ser_oe) begin
        check(0, "R10", ser_out, ser_oe, held_d, held_oe);
      end
    end
  end

  function automatic bit model_step();
    bit nb;
    nb = poly_sel ? (m_seq[22] ^ m_seq[17]) : (m_seq[14] ^ m_seq[13]);
    m_seq = {m_seq[21:0], nb};
    return nb;
  endfunction

  task automatic configure(input bit en, input bit poly, input logic [1:0] rate,
                           input logic [1:0] str, input int st, input int ln,
                           input string tag);
    if (!en || poly != poly_sel) m_seq = '1;
    tx_en = en; poly_sel = poly; rate_sel = rate; stream_sel = str;
    start_ch = 8'(st); len_ch = 8'(ln); cur_tag = tag;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input bit fs);
    exp_t e;
    int fb, ch;
    bit win;
    fb = 256 << rate_sel;
    if (fs) m_idx = 0;
    else m_idx = (m_idx >= fb - 1) ? 0 : m_idx + 1;
    ch = m_idx / 8;
    win = tx_en && ch >= int'(start_ch) && ch <= int'(start_ch) + int'(len_ch) && ch < (32 << rate_sel);
    sw_data = NSTR'($urandom);
    sw_oe   = NSTR'($urandom);
    e.d = sw_data; e.oe = sw_oe; e.tag = cur_tag;
    if (win) begin
      e.d[stream_sel]  = model_step();
      e.oe[stream_sel] = 1'b1;
    end
    q.push_back(e);
    frame_sync = fs; bit_en = 1;
    @(negedge clk);
    frame_sync = 0; bit_en = 0;
    @(negedge clk);
  endtask

  task automatic run_bits(input int n, input bit first_sync);
    for (int k = 0; k < n; k++) send_bit(first_sync && k == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: out=%b oe=%b expected completion", ser_out, ser_oe);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out == 0 && ser_oe == 0, "R1", ser_out, ser_oe, 0, 0);
    rst = 0;
    @(negedge clk);
    check(ser_out == 0 && ser_oe == 0, "R1", ser_out, ser_oe, 0, 0);

    // pass-through with insertion off
    configure(0, 0, 2'd0, 2'd1, 0, 255, "R2");
    run_bits(300, 1);

    // short sequence, stream 1, channels 3..5, across two frames (R3 R4 R5 R7)
    configure(1, 0, 2'd0, 2'd1, 3, 2, "R3 R4 R5 R7");
    run_bits(512, 1);
    run_bits(80, 0);

    // long sequence, rate 1, window truncated at channel 63 (R6 R8)
    configure(0, 1, 2'd1, 2'd2, 60, 10, "R6 R8");
    configure(1, 1, 2'd1, 2'd2, 60, 10, "R6 R8");
    run_bits(512, 1);
    run_bits(40, 0);

    // largest frame, window past the end on stream 0 (R8)
    configure(1, 1, 2'd3, 2'd0, 250, 20, "R8");
    run_bits(2048, 1);
    run_bits(24, 0);

    // start beyond the frame: no insertion (R8)
    configure(1, 0, 2'd0, 2'd3, 40, 3, "R8");
    run_bits(256, 1);

    // mid-frame marker realigns, wrap without marker (R9)
    configure(1, 0, 2'd0, 2'd0, 0, 0, "R9");
    run_bits(100, 1);
    run_bits(300, 1);

    // sequence state persists while insertion stays on (R7 R11)
    configure(1, 0, 2'd0, 2'd3, 10, 5, "R7 R11");
    run_bits(256 * 3, 1);

    repeat (4) @(negedge clk);
    check(q.size() == 0, "scoreboard drain", ser_out, ser_oe, ser_out, ser_oe);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule